// File: doc/BRIEF.md
# Split TLB Invalidation Permission Checker and Batch Sequencer

This block sits in the decode stage next to the address-translation cache and handles the fine-grained TLB maintenance operations. Each cycle it takes a decoded operation class, the current privilege level, the virtualization flag and the two trap-virtual-memory controls (one for the host, one for the guest). It returns a permission verdict for the operation: allow, illegal-instruction or virtual-instruction. The split invalidates, the two split ordering fences and the three full fences are all checked.

For operations that are allowed, a small sequencer lets split invalidates go out back to back. It does not stall the pipeline for each one. Issued invalidates are counted as pending work, and an invalidation engine retires one entry every `DRAIN_CYC` cycles. Only the implicit-reference fence and the full fences wait for the pending count to reach zero. The write-ordering fence never waits.

Each issued invalidation carries a tag. Guest-physical operations use the VMID and all other operations use the ASID. The parameter `SPLIT_EN` = 0 builds a variant without batching: split invalidates act as full fences, and both split fences are no-ops.

Top module: `tlb_inval_guard`

## Requirements
- R1: With `priv`=0 and `virt`=0 (user mode), every operation class gets `perm`=1 (illegal). Verdict codes: 0 allow, 1 illegal, 2 virtual. Class codes: 0 split supervisor invalidate, 1 split guest-virtual invalidate, 2 split guest-physical invalidate, 3 write-ordering fence, 4 implicit-reference fence, 5 full supervisor fence, 6 full guest-virtual fence, 7 full guest-physical fence.
- R2: In host supervisor mode (`priv`=1, `virt`=0), classes 0, 2, 5 and 7 are illegal when `tvm`=1 and allowed when `tvm`=0. Classes 1 and 6 are allowed whatever `tvm` is.
- R3: With `virt`=1 and `priv` set to 0 or 1, classes 1, 2, 6 and 7 give `perm`=2. With `virt`=1 and `priv`=0, classes 0 and 5 also give `perm`=2.
- R4: In guest supervisor mode (`priv`=1, `virt`=1), classes 0 and 5 give `perm`=2 when `vtvm`=1 and are allowed when `vtvm`=0. `tvm` has no effect on them in this mode.
- R5: Classes 3 and 4 give `perm`=2 with `priv`=0 and `virt`=1. They are allowed with `priv`=1 whatever `virt`, `tvm` and `vtvm` are.
- R6: With `priv`=3 (machine mode), every class is allowed.
- R7: An allowed split invalidate (classes 0–2) asserts `inv_fire` in the same cycle and adds one to the pending count. One pending entry retires every `DRAIN_CYC` cycles while the count is non-zero.
- R8: An allowed class 4 or full fence (classes 5–7) asserts `stall` while the pending count is non-zero. A full fence fires its invalidation in the first cycle it is not stalled. Class 3 never stalls and never fires.
- R9: An allowed split invalidate stalls and does not fire while the pending count is at its maximum of 2^`CNT_W`−1.
- R10: `inv_tag` carries `vmid` and `inv_by_vmid`=1 for classes 2 and 7. It carries `asid` and `inv_by_vmid`=0 for all other classes.
- R11: With `SPLIT_EN`=0, split invalidates fire at once and never stall, even after any number of them. Classes 3 and 4 neither stall nor fire.
- R12: An operation whose verdict is not allow neither fires nor changes the pending count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A maintenance operation is presented this cycle |
| op_cls | input | 3 | Operation class code (see R1) |
| priv | input | 2 | Privilege level: 0 user, 1 supervisor, 3 machine |
| virt | input | 1 | Virtualization active |
| tvm | input | 1 | Host trap-virtual-memory control |
| vtvm | input | 1 | Guest trap-virtual-memory control |
| asid | input | ID_W | Address-space identifier for non-guest-physical operations |
| vmid | input | ID_W | Virtual-machine identifier for guest-physical operations |
| perm | output | 2 | Verdict: 0 allow, 1 illegal, 2 virtual |
| stall | output | 1 | Hold the presented operation this cycle |
| inv_fire | output | 1 | Issue an invalidation to the translation cache |
| inv_by_vmid | output | 1 | Invalidation tag is a VMID |
| inv_tag | output | ID_W | ASID or VMID for the invalidation |

## Verification
The bench probes where the trap controls cross over. It applies `tvm`=1 in guest supervisor mode, where it must be ignored, and `vtvm`=1 in host mode. A design that mixed the two up would trap the wrong mode. It also checks the guest-virtual class in host mode, which `tvm` must not affect, and the split fences under both trap bits. A design that applied the invalidate rules to the fences would trap them.

On the sequencer side, the bench counts the exact number of stall cycles behind a batch of three invalidates and behind a single guest-physical invalidate. A design that drained the wrong way, or stalled on the write fence, would show a different count. The bench also fills the pending counter to its limit, where a design that wrapped the count would fire a ninth invalidate at once. Finally, it confirms that a trapped invalidate leaves no pending work behind and that the flat variant never stalls.

// File: rtl/tlb_inval_guard.sv
module tlb_inval_guard #(
  parameter int ID_W      = 16,
  parameter int CNT_W     = 3,
  parameter int DRAIN_CYC = 4,
  parameter bit SPLIT_EN  = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [2:0]      op_cls,
  input  logic [1:0]      priv,
  input  logic            virt,
  input  logic            tvm,
  input  logic            vtvm,
  input  logic [ID_W-1:0] asid,
  input  logic [ID_W-1:0] vmid,
  output logic [1:0]      perm,
  output logic            stall,
  output logic            inv_fire,
  output logic            inv_by_vmid,
  output logic [ID_W-1:0] inv_tag
);

  localparam logic [2:0] OP_SINV  = 3'd0;
  localparam logic [2:0] OP_GVINV = 3'd1;
  localparam logic [2:0] OP_GPINV = 3'd2;
  localparam logic [2:0] OP_WFNC  = 3'd3;
  localparam logic [2:0] OP_IRFNC = 3'd4;
  localparam logic [2:0] OP_SFULL = 3'd5;
  localparam logic [2:0] OP_HVFUL = 3'd6;
  localparam logic [2:0] OP_HGFUL = 3'd7;

  localparam logic [1:0] P_OK   = 2'd0;
  localparam logic [1:0] P_ILL  = 2'd1;
  localparam logic [1:0] P_VIRT = 2'd2;

  localparam int TMR_W = $clog2(DRAIN_CYC + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(DRAIN_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic is_sup, is_gv, is_gp, is_split_inv, is_full, is_irf;
  logic allowed, inc, dec, need_wait;
  logic [CNT_W-1:0] cnt_q;
  logic [TMR_W-1:0] tmr_q;

  assign is_sup       = (op_cls == OP_SINV)  || (op_cls == OP_SFULL);
  assign is_gv        = (op_cls == OP_GVINV) || (op_cls == OP_HVFUL);
  assign is_gp        = (op_cls == OP_GPINV) || (op_cls == OP_HGFUL);
  assign is_split_inv = (op_cls == OP_SINV) || (op_cls == OP_GVINV) || (op_cls == OP_GPINV);
  assign is_full      = (op_cls == OP_SFULL) || (op_cls == OP_HVFUL) || (op_cls == OP_HGFUL);
  assign is_irf       = (op_cls == OP_IRFNC);

  always_comb begin
    perm = P_OK;
    if (priv == 2'd3) begin
      perm = P_OK;
    end else if (priv == 2'd2) begin
      perm = P_ILL;
    end else if (priv == 2'd0) begin
      perm = virt ? P_VIRT : P_ILL;
    end else if (!virt) begin
      if ((is_sup || is_gp) && tvm) perm = P_ILL;
    end else begin
      if (is_gv || is_gp)          perm = P_VIRT;
      else if (is_sup && vtvm)     perm = P_VIRT;
    end
  end

  assign allowed = op_valid && (perm == P_OK);
  assign dec     = (cnt_q != '0) && (tmr_q == TMR_LAST);

  generate
    if (SPLIT_EN) begin : g_batched
      assign need_wait = (is_irf || is_full) ? (cnt_q != '0)
                       : is_split_inv        ? (cnt_q == CNT_MAX)
                       : 1'b0;
      assign inc = allowed && is_split_inv && !stall;
    end else begin : g_flat
      assign need_wait = 1'b0;
      assign inc       = 1'b0;
    end
  endgenerate

  assign stall       = allowed && need_wait;
  assign inv_fire    = allowed && (is_split_inv || is_full) && !stall;
  assign inv_by_vmid = is_gp;
  assign inv_tag     = is_gp ? vmid : asid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tmr_q <= '0;
    end else begin
      if (inc && !dec)      cnt_q <= cnt_q + 1'b1;
      else if (dec && !inc) cnt_q <= cnt_q - 1'b1;
      if ((cnt_q == '0) || dec) tmr_q <= '0;
      else                      tmr_q <= tmr_q + 1'b1;
    end
  end

  // R1
  user_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == 2'd0 && !virt) |-> perm == P_ILL);

  // R5
  fence_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_cls == OP_WFNC || op_cls == OP_IRFNC) && priv == 2'd1) |-> perm == P_OK);

  // R7
  pend_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_fire && is_split_inv && SPLIT_EN && !dec) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R7
  pend_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R8
  irf_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (SPLIT_EN && allowed && is_irf && cnt_q != '0) |-> stall && !inv_fire);

  // R9
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (allowed && is_split_inv && cnt_q == CNT_MAX) |=> cnt_q != '0);

  // R12
  trapped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && perm != P_OK) |-> !inv_fire && !stall);

endmodule

// File: tb/tlb_inval_guard_tb.sv
module tlb_inval_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [2:0] op_cls = '0;
  logic [1:0] priv = '0;
  logic virt = 1'b0, tvm = 1'b0, vtvm = 1'b0;
  logic [15:0] asid = 16'h00A5, vmid = 16'h3C01;
  logic [1:0] perm, perm_off;
  logic stall, inv_fire, inv_by_vmid, stall_off, fire_off, byv_off;
  logic [15:0] inv_tag, tag_off;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_inval_guard dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_cls(op_cls), .priv(priv),
    .virt(virt), .tvm(tvm), .vtvm(vtvm), .asid(asid), .vmid(vmid),
    .perm(perm), .stall(stall), .inv_fire(inv_fire), .inv_by_vmid(inv_by_vmid),
    .inv_tag(inv_tag));

  tlb_inval_guard #(.SPLIT_EN(1'b0)) dut_off_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_cls(op_cls), .priv(priv),
    .virt(virt), .tvm(tvm), .vtvm(vtvm), .asid(asid), .vmid(vmid),
    .perm(perm_off), .stall(stall_off), .inv_fire(fire_off), .inv_by_vmid(byv_off),
    .inv_tag(tag_off));

  // {cls, priv, virt, tvm, vtvm, expected verdict, requirement}
  localparam logic [13:0] VEC [NV] = '{
    {3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1, 4'd1},  // R1
    {3'd3, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1, 4'd1},  // R1
    {3'd4, 2'd0, 1'b0, 1'b1, 1'b1, 2'd1, 4'd1},  // R1
    {3'd7, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1, 4'd1},  // R1
    {3'd0, 2'd1, 1'b0, 1'b1, 1'b0, 2'd1, 4'd2},  // R2
    {3'd2, 2'd1, 1'b0, 1'b1, 1'b0, 2'd1, 4'd2},  // R2
    {3'd0, 2'd1, 1'b0, 1'b0, 1'b1, 2'd0, 4'd2},  // R2
    {3'd1, 2'd1, 1'b0, 1'b1, 1'b0, 2'd0, 4'd2},  // R2
    {3'd7, 2'd1, 1'b0, 1'b1, 1'b0, 2'd1, 4'd2},  // R2
    {3'd1, 2'd1, 1'b1, 1'b0, 1'b0, 2'd2, 4'd3},  // R3
    {3'd2, 2'd0, 1'b1, 1'b0, 1'b0, 2'd2, 4'd3},  // R3
    {3'd0, 2'd0, 1'b1, 1'b0, 1'b0, 2'd2, 4'd3},  // R3
    {3'd6, 2'd1, 1'b1, 1'b0, 1'b0, 2'd2, 4'd3},  // R3
    {3'd0, 2'd1, 1'b1, 1'b0, 1'b1, 2'd2, 4'd4},  // R4
    {3'd0, 2'd1, 1'b1, 1'b1, 1'b0, 2'd0, 4'd4},  // R4
    {3'd5, 2'd1, 1'b1, 1'b0, 1'b1, 2'd2, 4'd4},  // R4
    {3'd3, 2'd0, 1'b1, 1'b0, 1'b0, 2'd2, 4'd5},  // R5
    {3'd4, 2'd0, 1'b1, 1'b0, 1'b0, 2'd2, 4'd5},  // R5
    {3'd3, 2'd1, 1'b0, 1'b1, 1'b1, 2'd0, 4'd5},  // R5
    {3'd4, 2'd1, 1'b1, 1'b1, 1'b1, 2'd0, 4'd5},  // R5
    {3'd2, 2'd3, 1'b0, 1'b1, 1'b1, 2'd0, 4'd6},  // R6
    {3'd0, 2'd3, 1'b0, 1'b1, 1'b1, 2'd0, 4'd6}   // R6
  };

  task automatic chk(input int act, input int exp, input string req, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input bit v, input logic [2:0] c, input logic [1:0] p,
                       input bit vi, input bit t, input bit vt);
    @(negedge clk);
    op_valid = v; op_cls = c; priv = p; virt = vi; tvm = t; vtvm = vt;
    #2;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state: R8 allowed fence with empty pending count does not stall
    drive(1, 3'd4, 2'd1, 0, 0, 0);
    chk(stall, 0, "R8", "reset stall");
    chk(inv_fire, 0, "R8", "reset fire on fence");

    for (int i = 0; i < NV; i++) begin
      drive(0, VEC[i][13:11], VEC[i][10:9], VEC[i][8], VEC[i][7], VEC[i][6]);
      chk(perm, VEC[i][5:4], $sformatf("R%0d", VEC[i][3:0]), $sformatf("verdict vec %0d", i));
    end

    // R7 R10: three split invalidates back to back
    for (int i = 0; i < 3; i++) begin
      drive(1, 3'd0, 2'd1, 0, 0, 0);
      chk(inv_fire, 1, "R7", "split inval fires");
      chk(stall, 0, "R7", "split inval no stall");
      chk(inv_tag, 16'h00A5, "R10", "asid tag");
      chk(inv_by_vmid, 0, "R10", "asid select");
    end
    // R8 write fence never stalls
    drive(1, 3'd3, 2'd1, 0, 0, 0);
    chk(stall, 0, "R8", "write fence stall");
    chk(inv_fire, 0, "R8", "write fence fire");
    // R8 implicit-reference fence waits for drain
    drive(1, 3'd4, 2'd1, 0, 0, 0);
    chk(stall_off, 0, "R11", "flat variant fence stall");
    n = 0;
    while (stall && n < 60) begin n++; @(negedge clk); #2; end
    chk(n, 9, "R7", "stall cycles behind three invalidates");
    chk(inv_fire, 0, "R8", "ir fence fire");

    // R10 guest-physical uses vmid
    drive(1, 3'd2, 2'd1, 0, 0, 0);
    chk(inv_fire, 1, "R10", "gp inval fires");
    chk(inv_tag, 16'h3C01, "R10", "vmid tag");
    chk(inv_by_vmid, 1, "R10", "vmid select");
    // R8 full fence waits then fires
    drive(1, 3'd5, 2'd1, 0, 0, 0);
    n = 0;
    while (stall && n < 60) begin
      chk(inv_fire, 0, "R8", "full fence fire while stalled");
      n++; @(negedge clk); #2;
    end
    chk(n, 4, "R8", "full fence stall cycles");
    chk(inv_fire, 1, "R8", "full fence fires after drain");

    // R12 trapped invalidate leaves nothing pending
    drive(1, 3'd0, 2'd1, 0, 1, 0);
    chk(inv_fire, 0, "R12", "trapped fire");
    drive(1, 3'd4, 2'd1, 0, 0, 0);
    chk(stall, 0, "R12", "fence after trapped inval");

    // R9 saturation of the pending count
    for (int i = 0; i < 8; i++) begin
      drive(1, 3'd1, 2'd1, 0, 0, 0);
      chk(inv_fire, 1, "R9", "fire before saturation");
    end
    drive(1, 3'd1, 2'd1, 0, 0, 0);
    chk(stall, 1, "R9", "stall at max");
    chk(inv_fire, 0, "R9", "no fire at max");
    chk(stall_off, 0, "R11", "flat variant inval stall");
    chk(fire_off, 1, "R11", "flat variant inval fire");
    drive(1, 3'd1, 2'd1, 0, 0, 0);
    chk(stall, 0, "R9", "stall released");
    chk(inv_fire, 1, "R9", "fire after release");

    // R11 flat variant fences are no-ops
    drive(1, 3'd4, 2'd1, 0, 0, 0);
    chk(stall, 1, "R8", "ir fence stalls while pending");
    chk(stall_off, 0, "R11", "flat ir fence stall");
    chk(fire_off, 0, "R11", "flat ir fence fire");
    drive(1, 3'd3, 2'd1, 0, 0, 0);
    chk(fire_off, 0, "R11", "flat write fence fire");

    drive(0, 3'd0, 2'd1, 0, 0, 0);
    repeat (60) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule